// File: doc/BRIEF.md
# Packed Immediate Bit-Manipulation Unit

This unit executes one vector instruction in the bit-immediate format against a 128-bit source vector and the previous value of the 128-bit destination vector. The 7-bit field at instruction bits 22:16 is a prefix code. Its leading bits choose a lane width of 8, 16, 32 or 64 bits, and the remaining bits give an immediate `m`. Every lane of the vector is then processed at the same time by one of eight operations: three shifts, three single-bit edits and two bit-field inserts.

An instruction is presented with a one-cycle `in_valid` pulse. One clock later the unit raises either `out_wr`, which carries a registered 128-bit result that the register file should write, or `out_resv`, which flags the word as a reserved instruction. When `out_resv` is raised, no write takes place and the result register keeps its previous value. The register indices at bits 15:11 and 10:6 are not used here.

Top module: `bitimm_unit`

## Requirements
- R1: The field at bits 22:16 is decoded as a prefix code. Pattern 0xxxxxx selects 64-bit lanes with m = bits 5:0. Pattern 10xxxxx selects 32-bit lanes with m = bits 4:0. Pattern 110xxxx selects 16-bit lanes with m = bits 3:0. Pattern 1110xxx selects 8-bit lanes with m = bits 2:0. Every lane uses the same m.
- R2: A word is reserved if field pattern 1111xxx appears, if bits 31:26 differ from 011110, or if bits 5:0 differ from 001001. For a reserved word, `out_resv` pulses, `out_wr` stays low and `out_result` is unchanged.
- R3: Bits 25:23 select the operation: 0 shift left, 1 arithmetic shift right, 2 logical shift right, 3 clear bit, 4 set bit, 5 toggle bit, 6 insert from left, 7 insert from right.
- R4: Shift left fills with zeros. Arithmetic shift right copies the lane sign bit into the vacated bits. Logical shift right fills with zeros. Each shift moves the lane by m places.
- R5: Clear, set and toggle change only bit m of each lane and leave every other bit of the lane as it was in the source.
- R6: Insert-from-left takes the top m+1 bits of each lane from the source and the lower bits from the old destination. When m+1 equals the lane width, the whole source lane is used.
- R7: Insert-from-right takes the low m+1 bits of each lane from the source and the upper bits from the old destination. When m+1 equals the lane width, the whole source lane is used.
- R8: A valid input produces exactly one pulse on either `out_wr` or `out_resv` in the next cycle, never both. With no valid input, neither output pulses.
- R9: Reset clears `out_wr`, `out_resv` and `out_result` to zero.
- R10: `out_result` changes only in the cycle in which `out_wr` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Instruction present this cycle |
| instr | input | 32 | Instruction word |
| src_vec | input | 128 | Source vector |
| dst_old | input | 128 | Previous destination vector |
| out_wr | output | 1 | Result valid, write it back |
| out_resv | output | 1 | Reserved-instruction flag |
| out_result | output | 128 | Registered result |

## Verification
A reserved word can arrive in the cycle right after a legal one. In that case the registered result from the first word is still being presented while the reserved flag for the second word is about to rise. The bench drives legal and reserved words back to back, and also mixes them into a random stream with idle gaps. Its reference model checks, on every clock, that the flag rises without disturbing the held result. It also checks that the next legal word replaces that result one cycle after it is presented.

// File: rtl/bitimm_pkg.sv
package bitimm_pkg;
  localparam int VEC_W = 128;
  localparam int NUM_WIDTHS = 4;

  typedef enum logic [1:0] {
    LW8  = 2'd0,
    LW16 = 2'd1,
    LW32 = 2'd2,
    LW64 = 2'd3
  } lane_e;

  typedef enum logic [2:0] {
    OP_SHL   = 3'd0,
    OP_SHRA  = 3'd1,
    OP_SHRL  = 3'd2,
    OP_CLR   = 3'd3,
    OP_SET   = 3'd4,
    OP_TOG   = 3'd5,
    OP_INSL  = 3'd6,
    OP_INSR  = 3'd7
  } op_e;
endpackage

// File: rtl/bitimm_decode.sv
module bitimm_decode
  import bitimm_pkg::*;
#(
  parameter logic [5:0] MAJOR_OPC = 6'b011110,
  parameter logic [5:0] MINOR_OPC = 6'b001001
) (
  input  logic [31:0] instr,
  output lane_e       lane,
  output logic [5:0]  imm_m,
  output op_e         op,
  output logic        legal
);
  logic [6:0] fmt;
  logic       fmt_ok;
  logic       unused_regidx;

  assign fmt           = instr[22:16];
  assign unused_regidx = ^instr[15:6];

  always_comb begin
    fmt_ok = 1'b1;
    lane   = LW64;
    imm_m  = 6'd0;
    casez (fmt)
      7'b0??????: begin lane = LW64; imm_m = fmt[5:0];          end
      7'b10?????: begin lane = LW32; imm_m = {1'b0,  fmt[4:0]}; end
      7'b110????: begin lane = LW16; imm_m = {2'b00, fmt[3:0]}; end
      7'b1110???: begin lane = LW8;  imm_m = {3'b000, fmt[2:0]}; end
      default:    fmt_ok = 1'b0;
    endcase
  end

  assign op    = op_e'(instr[25:23]);
  assign legal = fmt_ok && (instr[31:26] == MAJOR_OPC) && (instr[5:0] == MINOR_OPC);
endmodule

// File: rtl/bitimm_lane.sv
module bitimm_lane
  import bitimm_pkg::*;
#(
  parameter int W = 8,
  localparam int SHW = $clog2(W)
) (
  input  logic [W-1:0]   a,
  input  logic [W-1:0]   d,
  input  logic [SHW-1:0] sh,
  input  op_e            op,
  output logic [W-1:0]   y
);
  logic [W-1:0] ones;
  logic [W-1:0] onehot;
  logic [W-1:0] below_top;
  logic [W-1:0] low_keep;

  assign ones      = {W{1'b1}};
  assign onehot    = {{(W-1){1'b0}}, 1'b1} << sh;
  // bits not covered by the top sh+1 positions
  assign below_top = (ones >> sh) >> 1;
  // low sh+1 positions
  assign low_keep  = ~((ones << sh) << 1);

  always_comb begin
    unique case (op)
      OP_SHL:  y = a << sh;
      OP_SHRA: y = W'($signed(a) >>> sh);
      OP_SHRL: y = a >> sh;
      OP_CLR:  y = a & ~onehot;
      OP_SET:  y = a | onehot;
      OP_TOG:  y = a ^ onehot;
      OP_INSL: y = (a & ~below_top) | (d & below_top);
      OP_INSR: y = (a & low_keep) | (d & ~low_keep);
      default: y = a;
    endcase
  end
endmodule

// File: rtl/bitimm_unit.sv
module bitimm_unit
  import bitimm_pkg::*;
#(
  parameter logic [5:0] MAJOR_OPC = 6'b011110,
  parameter logic [5:0] MINOR_OPC = 6'b001001
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [31:0]       instr,
  input  logic [VEC_W-1:0]  src_vec,
  input  logic [VEC_W-1:0]  dst_old,
  output logic              out_wr,
  output logic              out_resv,
  output logic [VEC_W-1:0]  out_result
);
  lane_e            lane;
  logic [5:0]       imm_m;
  op_e              op;
  logic             legal;
  logic [VEC_W-1:0] res_by_w [NUM_WIDTHS];
  logic [VEC_W-1:0] res_sel;
  logic             wr_nxt;
  logic             resv_nxt;
  logic             res_en;

  bitimm_decode #(
    .MAJOR_OPC (MAJOR_OPC),
    .MINOR_OPC (MINOR_OPC)
  ) u_dec (
    .instr (instr),
    .lane  (lane),
    .imm_m (imm_m),
    .op    (op),
    .legal (legal)
  );

  for (genvar g = 0; g < NUM_WIDTHS; g++) begin : g_width
    localparam int LW    = 8 << g;
    localparam int SHW   = 3 + g;
    localparam int NLANE = VEC_W / LW;
    for (genvar i = 0; i < NLANE; i++) begin : g_lane
      bitimm_lane #(.W(LW)) u_lane (
        .a  (src_vec[i*LW +: LW]),
        .d  (dst_old[i*LW +: LW]),
        .sh (imm_m[SHW-1:0]),
        .op (op),
        .y  (res_by_w[g][i*LW +: LW])
      );
    end
  end

  // next-state
  always_comb begin
    res_sel  = res_by_w[lane];
    wr_nxt   = in_valid && legal;
    resv_nxt = in_valid && !legal;
    res_en   = wr_nxt;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_wr   <= 1'b0;
      out_resv <= 1'b0;
    end else begin
      out_wr   <= wr_nxt;
      out_resv <= resv_nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_result <= '0;
    end else if (res_en) begin
      out_result <= res_sel;
    end
  end
endmodule

// File: rtl/bitimm_chk.sv
module bitimm_chk (
  input logic         clk,
  input logic         rst_n,
  input logic         in_valid,
  input logic [31:0]  instr,
  input logic [127:0] src_vec,
  input logic         out_wr,
  input logic         out_resv,
  input logic [127:0] out_result
);
  logic enc_ok;
  assign enc_ok = (instr[31:26] == 6'b011110) && (instr[5:0] == 6'b001001);

  assert_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(out_wr && out_resv));

  assert_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_wr && !out_resv));

  assert_resv_fmt_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && instr[22:19] == 4'hF) |=> (out_resv && !out_wr));

  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(out_result));

  assert_shl_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && enc_ok && instr[25:23] == 3'd0 && instr[22:16] == 7'h00)
      |=> (out_wr && out_result == $past(src_vec)));

  assert_legal_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && enc_ok && !instr[22]) |=> out_wr);
endmodule

bind bitimm_unit bitimm_chk u_chk (.*);

// File: tb/bitimm_unit_tb.sv
`timescale 1ns/1ps
module bitimm_unit_tb;
  logic         clk = 1'b0;
  logic         rst_n;
  logic         in_valid;
  logic [31:0]  instr;
  logic [127:0] src_vec;
  logic [127:0] dst_old;
  logic         out_wr;
  logic         out_resv;
  logic [127:0] out_result;

  int total = 0;
  int bad = 0;
  bit done = 0;

  logic         exp_wr = 0;
  logic         exp_resv = 0;
  logic [127:0] exp_res = '0;
  string        exp_tag = "R9";

  always #2 clk = ~clk;

  bitimm_unit u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .instr(instr),
    .src_vec(src_vec), .dst_old(dst_old), .out_wr(out_wr),
    .out_resv(out_resv), .out_result(out_result)
  );

  function automatic logic [31:0] mk(input logic [2:0] op, input logic [6:0] fmt);
    return {6'b011110, op, fmt, 5'd3, 5'd7, 6'b001001};
  endfunction

  function automatic bit ref_legal(input logic [31:0] ins);
    return ins[31:26] == 6'b011110 && ins[5:0] == 6'b001001 && ins[22:19] != 4'hF;
  endfunction

  function automatic logic [63:0] ref_lane(input int op, input int w, input int m,
                                           input logic [63:0] a, input logic [63:0] d);
    logic [63:0] mask, sa, top, lo;
    int n;
    mask = (w == 64) ? {64{1'b1}} : ((64'd1 << w) - 64'd1);
    sa = a;
    if (a[w-1]) sa = a | ~mask;
    n = m + 1;
    case (op)
      0: return (a << m) & mask;
      1: return 64'($signed(sa) >>> m) & mask;
      2: return a >> m;
      3: return a & ~(64'd1 << m);
      4: return (a | (64'd1 << m)) & mask;
      5: return (a ^ (64'd1 << m)) & mask;
      6: begin
        if (n == w) return a;
        top = mask & ~(mask >> n);
        return (a & top) | (d & ~top & mask);
      end
      default: begin
        if (n == w) return a;
        lo = (64'd1 << n) - 64'd1;
        return (a & lo) | (d & ~lo & mask);
      end
    endcase
  endfunction

  function automatic logic [127:0] ref_vec(input logic [31:0] ins,
                                          input logic [127:0] s, input logic [127:0] d);
    logic [127:0] r;
    logic [6:0] f;
    int w, m;
    f = ins[22:16];
    if (!f[6])              begin w = 64; m = int'(f[5:0]); end
    else if (f[6:5] == 2'b10)  begin w = 32; m = int'(f[4:0]); end
    else if (f[6:4] == 3'b110) begin w = 16; m = int'(f[3:0]); end
    else                     begin w = 8;  m = int'(f[2:0]); end
    r = '0;
    for (int i = 0; i < 128 / w; i++) begin
      logic [63:0] a, dd, y;
      a = '0; dd = '0;
      for (int b = 0; b < w; b++) begin a[b] = s[i*w+b]; dd[b] = d[i*w+b]; end
      y = ref_lane(int'(ins[25:23]), w, m, a, dd);
      for (int b = 0; b < w; b++) r[i*w+b] = y[b];
    end
    return r;
  endfunction

  task automatic check_now();
    total++;
    if (out_wr !== exp_wr) begin
      bad++; $display("FAIL R8 out_wr actual=%0b expected=%0b", out_wr, exp_wr);
    end
    total++;
    if (out_resv !== exp_resv) begin
      bad++; $display("FAIL R2 out_resv actual=%0b expected=%0b", out_resv, exp_resv);
    end
    total++;
    if (out_result !== exp_res) begin
      bad++; $display("FAIL %s out_result actual=%h expected=%h", exp_tag, out_result, exp_res);
    end
  endtask

  task automatic step(input logic v, input logic [31:0] ins, input logic [127:0] s,
                      input logic [127:0] d, input string tag);
    @(negedge clk);
    check_now();
    in_valid = v; instr = ins; src_vec = s; dst_old = d;
    exp_tag = v ? tag : "R10";
    if (!v) begin exp_wr = 0; exp_resv = 0; end
    else if (ref_legal(ins)) begin exp_wr = 1; exp_resv = 0; exp_res = ref_vec(ins, s, d); end
    else begin exp_wr = 0; exp_resv = 1; end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; in_valid = 0;
    exp_wr = 0; exp_resv = 0; exp_res = '0; exp_tag = "R9";
    @(negedge clk);
    check_now();
    rst_n = 1;
  endtask

  initial begin
    #(4 * 150000);
    bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
    end
    $finish;
  end

  localparam logic [127:0] PA = 128'h8123_4567_89AB_CDEF_F0E1_D2C3_B4A5_9687;
  localparam logic [127:0] PB = 128'h0F0F_1234_AAAA_5555_7F80_0180_FFFF_0000;

  initial begin
    rst_n = 0; in_valid = 0; instr = '0; src_vec = '0; dst_old = '0;
    repeat (2) @(negedge clk);
    check_now();                          // R9 reset state
    rst_n = 1;

    step(1, mk(3'd0, 7'h00), PA, PB, "R4");          // R4 shift by 0, 64-bit
    step(1, mk(3'd0, 7'b0000100), PA, PB, "R1");     // R1 64-bit lanes m=4
    step(1, mk(3'd1, 7'b1000101), PA, PB, "R1");     // R1 32-bit lanes
    step(1, mk(3'd2, 7'b1100011), PA, PB, "R1");     // R1 16-bit lanes
    step(1, mk(3'd1, 7'b1110111), PA, PB, "R4");     // R4 arithmetic, byte, m=7
    for (int op = 0; op < 8; op++)                   // R3 every code
      step(1, mk(3'(op), 7'b1010011), PA, PB, "R3");
    step(1, mk(3'd3, 7'b0111111), PA, PB, "R5");     // R5 clear top bit 64
    step(1, mk(3'd4, 7'b1110000), PB, PA, "R5");
    step(1, mk(3'd5, 7'b1101111), PA, PB, "R5");
    step(1, mk(3'd6, 7'b1110111), PA, PB, "R6");     // R6 full byte lane
    step(1, mk(3'd6, 7'b1100010), PA, PB, "R6");
    step(1, mk(3'd6, 7'b0111111), PA, PB, "R6");     // R6 full 64 lane
    step(1, mk(3'd7, 7'b1011111), PA, PB, "R7");     // R7 full 32 lane
    step(1, mk(3'd7, 7'b0000000), PA, PB, "R7");     // R7 one bit
    step(1, mk(3'd7, 7'b1110010), PA, PB, "R7");
    step(1, mk(3'd0, 7'b1111010), PB, PA, "R2");     // R2 reserved format, back to back
    step(1, mk(3'd1, 7'b0000001), PB, PA, "R2");
    step(1, mk(3'd1, 7'b0000001) ^ 32'h1, PA, PB, "R2"); // R2 wrong minor
    step(1, mk(3'd1, 7'b0000001) ^ 32'h8000_0000, PA, PB, "R2"); // R2 wrong major
    step(0, '0, PA, PB, "R10");
    step(0, '0, PA, PB, "R10");                      // R10 hold while idle
    step(1, mk(3'd2, 7'b0000011), PA, PB, "R8");
    do_reset();                                      // R9 reset after activity
    for (int k = 0; k < 600; k++) begin
      logic [31:0] ins;
      logic [127:0] s, d;
      int tagsel;
      ins = $urandom;
      ins[31:26] = ($urandom % 10 == 0) ? 6'b000000 : 6'b011110;
      ins[5:0]   = ($urandom % 10 == 0) ? 6'b001010 : 6'b001001;
      s = {$urandom, $urandom, $urandom, $urandom};
      d = {$urandom, $urandom, $urandom, $urandom};
      tagsel = int'(ins[25:23]);
      step(($urandom % 4) != 0, ins, s, d,
           !ref_legal(ins) ? "R2" : tagsel < 3 ? "R4" : tagsel < 6 ? "R5" :
           tagsel == 6 ? "R6" : "R7");
    end
    step(0, '0, '0, '0, "R10");
    @(negedge clk);
    check_now();
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
    end
    $finish;
  end
endmodule